// File: doc/BRIEF.md
# Configurable Multi-Mode I/O Port

An 8-bit general-purpose port for a programmable peripheral that sits on a microcontroller bus. Software programs three per-bit registers: output data, direction and control. The port can also take a per-bit output-enable term that external logic produces, together with a flag that says whether that term is in use. A port-level mode input chooses one of three behaviours. In plain register I/O, output pins drive the data register. In address-out, the pins present the low byte of the bus address. In address-in, the pins are sampled into a latch by the address strobe.

In address-out mode the source of the address depends on the bus type. On a non-multiplexed bus the pins carry the live low address lines. On a multiplexed address/data bus they carry a copy of the address held by the strobe. This copy is transparent while the strobe is high and is held once the strobe falls. Each pad gets a data-out bit and an output-enable bit, which an external tristate buffer uses. All output enables are combinational functions of registered state, the mode inputs and the output-enable term.

Top module: `io_port_ctl`

## Requirements
- R1: After reset, the data, direction and control registers read 0 and every pad output enable is 0.
- R2: In register mode (mode 0, and also mode 3) with the product-term flag low, the pad enable of each bit equals its direction bit.
- R3: In register mode with the product-term flag high, the pad enable of each bit is its direction bit OR its product-term bit.
- R4: In address-out mode (mode 1), a pin is enabled when its product-term bit is 1 with the flag high, or when both its direction bit and its control bit are 1. A control bit alone does not enable the pin.
- R5: In address-out mode on a non-multiplexed bus (mux_bus_i=0), pad_o equals the live address bits [7:0].
- R6: In address-out mode on a multiplexed bus, pad_o follows address [7:0] while ale_i is high. After ale_i falls, pad_o keeps the value sampled at the last clock edge with ale_i high, and later changes on the address do not affect it.
- R7: In address-in mode (mode 2), all pad enables are 0. The pad levels are captured at each clock edge while ale_i is high and are held while it is low. The held value reads back with rd_sel_i=3.
- R8: In register mode, pad_o equals the data register.
- R9: A read with rd_sel_i=0 returns, for each bit, pad_o where the pad is enabled and pad_i where it is not.
- R10: A write with wr_sel_i = 0 (data), 1 (direction) or 2 (control) takes effect at the next clock edge. rd_sel_i=1 reads back the direction register and rd_sel_i=2 reads back the control register. wr_sel_i=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 data, 1 direction, 2 control |
| wr_data_i | input | WIDTH | Write data |
| rd_sel_i | input | 2 | Read source: 0 pins, 1 direction, 2 control, 3 address-in latch |
| rd_data_o | output | WIDTH | Read data |
| mode_i | input | 2 | 0 register, 1 address-out, 2 address-in, 3 register |
| mux_bus_i | input | 1 | 1 when the bus is multiplexed address/data |
| pt_en_i | input | 1 | Product-term output enable is in use |
| pt_oe_i | input | WIDTH | Product-term output enable per bit |
| addr_i | input | ADDR_W | Bus address |
| ale_i | input | 1 | Address strobe |
| pad_i | input | WIDTH | Pad input levels |
| pad_o | output | WIDTH | Pad output data |
| pad_oe_o | output | WIDTH | Pad output enables |

## Verification
The bench builds the port with WIDTH=8 and ADDR_W=16. With these values the upper address byte can be set different from the lower one, so a pin that picked the wrong address byte shows up at once. The eight bits also allow direction, control and product-term patterns in which every combination of the three appears on some bit within a single comparison.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  typedef enum logic [1:0] {
    MODE_REG     = 2'd0,
    MODE_ADR_OUT = 2'd1,
    MODE_ADR_IN  = 2'd2,
    MODE_REG_ALT = 2'd3
  } port_mode_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_AUX  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/io_port_regs.sv
module io_port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] ctrl_o
);
  import io_port_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      dir_o  <= '0;
      ctrl_o <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_DATA: data_o <= wr_data_i;
        SEL_DIR:  dir_o  <= wr_data_i;
        SEL_CTRL: ctrl_o <= wr_data_i;
        default:  ;
      endcase
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (dir_o == '0 && ctrl_o == '0 && data_o == '0); // R1
  end

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd1 |=> dir_o == $past(wr_data_i)); // R10
  AST_AUX_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd3 |=> $stable(dir_o) && $stable(ctrl_o) && $stable(data_o)); // R10
endmodule

// File: rtl/io_port_strobe_latch.sv
module io_port_strobe_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ale_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] held_o,
  output logic [WIDTH-1:0] flow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    held_o <= '0;
    else if (ale_i) held_o <= d_i;
  end

  // transparent while strobe high, holds afterwards
  assign flow_o = ale_i ? d_i : held_o;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(held_o)); // R7
  AST_LATCH_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> held_o == $past(d_i)); // R6
endmodule

// File: rtl/io_port_pin_mux.sv
module io_port_pin_mux #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             mux_bus_i,
  input  logic             pt_en_i,
  input  logic [WIDTH-1:0] pt_oe_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] ctrl_i,
  input  logic [WIDTH-1:0] adr_live_i,
  input  logic [WIDTH-1:0] adr_lat_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pin_rd_o
);
  import io_port_pkg::*;

  port_mode_e mode;
  assign mode = port_mode_e'(mode_i);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic pt_b;
    assign pt_b = pt_en_i & pt_oe_i[b];

    always_comb begin
      unique case (mode)
        MODE_ADR_OUT: begin
          pad_oe_o[b] = pt_b | (dir_i[b] & ctrl_i[b]);
          pad_o[b]    = mux_bus_i ? adr_lat_i[b] : adr_live_i[b];
        end
        MODE_ADR_IN: begin
          pad_oe_o[b] = 1'b0;
          pad_o[b]    = data_i[b];
        end
        default: begin
          pad_oe_o[b] = dir_i[b] | pt_b;
          pad_o[b]    = data_i[b];
        end
      endcase
    end

    assign pin_rd_o[b] = pad_oe_o[b] ? pad_o[b] : pad_i[b];
  end

  AST_ADR_IN_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |-> pad_oe_o == '0); // R7
  AST_REG_DIR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd3) |-> (pad_oe_o & dir_i) == dir_i); // R2
  AST_NO_PT_NO_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pt_en_i && mode_i != 2'd1 |-> (pad_oe_o & ~dir_i) == '0); // R2
  AST_CTRL_ALONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd1 && !pt_en_i |-> (pad_oe_o & ~dir_i) == '0); // R4
endmodule

// File: rtl/io_port_ctl.sv
module io_port_ctl #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [WIDTH-1:0]  rd_data_o,
  input  logic [1:0]        mode_i,
  input  logic              mux_bus_i,
  input  logic              pt_en_i,
  input  logic [WIDTH-1:0]  pt_oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ale_i,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  pad_oe_o
);
  import io_port_pkg::*;

  localparam int LOW_W = (WIDTH < ADDR_W) ? WIDTH : ADDR_W;

  logic [WIDTH-1:0] data_q, dir_q, ctrl_q;
  logic [WIDTH-1:0] adr_low, adr_lat, adr_lat_held;
  logic [WIDTH-1:0] adr_in_q, adr_in_flow;
  logic [WIDTH-1:0] pin_rd;

  always_comb begin
    adr_low = '0;
    adr_low[LOW_W-1:0] = addr_i[LOW_W-1:0];
  end

  io_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .data_o(data_q), .dir_o(dir_q), .ctrl_o(ctrl_q)
  );

  io_port_strobe_latch #(.WIDTH(WIDTH)) u_adr_out_lat (
    .clk_i, .rst_ni, .ale_i, .d_i(adr_low),
    .held_o(adr_lat_held), .flow_o(adr_lat)
  );

  io_port_strobe_latch #(.WIDTH(WIDTH)) u_adr_in_lat (
    .clk_i, .rst_ni, .ale_i, .d_i(pad_i),
    .held_o(adr_in_q), .flow_o(adr_in_flow)
  );

  io_port_pin_mux #(.WIDTH(WIDTH)) u_pins (
    .clk_i, .rst_ni, .mode_i, .mux_bus_i, .pt_en_i, .pt_oe_i,
    .data_i(data_q), .dir_i(dir_q), .ctrl_i(ctrl_q),
    .adr_live_i(adr_low), .adr_lat_i(adr_lat), .pad_i,
    .pad_o, .pad_oe_o, .pin_rd_o(pin_rd)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_DIR:  rd_data_o = dir_q;
      SEL_CTRL: rd_data_o = ctrl_q;
      SEL_AUX:  rd_data_o = adr_in_q;
      default:  rd_data_o = pin_rd;
    endcase
  end

  AST_MUX_HELD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd1 && mux_bus_i && !ale_i |-> pad_o == adr_lat_held); // R6
  AST_READ_INPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i == 2'd0 |-> (rd_data_o & ~pad_oe_o) == (pad_i & ~pad_oe_o)); // R9
endmodule

// File: tb/tb_io_port_ctl.sv
`timescale 1ns/1ps
module tb_io_port_ctl;
  localparam int W = 8;
  localparam int AW = 16;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0, mode = 0;
  logic [W-1:0] wr_data = 0, pt_oe = 0, pad_in = 0;
  logic mux_bus = 0, pt_en = 0, ale = 0;
  logic [AW-1:0] addr = 0;
  logic [W-1:0] rd_data, pad_out, pad_oe;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  io_port_ctl #(.WIDTH(W), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .mode_i(mode), .mux_bus_i(mux_bus),
    .pt_en_i(pt_en), .pt_oe_i(pt_oe), .addr_i(addr), .ale_i(ale), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write(logic [1:0] sel, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset;
    rd_sel = 1; #1 check("R1 dir", rd_data, 8'h00);
    rd_sel = 2; #1 check("R1 ctrl", rd_data, 8'h00);
    mode = 0; #1 check("R1 oe", pad_oe, 8'h00);
    check("R1 data", pad_out, 8'h00);
  endtask

  task automatic t_regs;
    write(1, 8'hA5);
    rd_sel = 1; #1 check("R10 dir", rd_data, 8'hA5);
    write(2, 8'h3C);
    rd_sel = 2; #1 check("R10 ctrl", rd_data, 8'h3C);
    write(3, 8'hFF);
    rd_sel = 1; #1 check("R10 aux dir", rd_data, 8'hA5);
    rd_sel = 2; #1 check("R10 aux ctrl", rd_data, 8'h3C);
    write(0, 8'h96);
    mode = 0; #1 check("R8 data", pad_out, 8'h96);
  endtask

  task automatic t_reg_oe;
    mode = 0; pt_en = 0; pt_oe = 8'h0F; #1
    check("R2 oe=dir", pad_oe, 8'hA5);
    mode = 3; #1 check("R2 mode3", pad_oe, 8'hA5);
    pt_en = 1; #1 check("R3 oe=dir|pt", pad_oe, 8'hAF);
    mode = 0; #1 check("R3 mode0", pad_oe, 8'hAF);
    pad_in = 8'h5A; rd_sel = 0; #1
    check("R9 read", rd_data, (8'h96 & 8'hAF) | (8'h5A & 8'h50));
    pt_en = 0; #1
    check("R9 read nopt", rd_data, (8'h96 & 8'hA5) | (8'h5A & 8'h5A));
  endtask

  task automatic t_adr_out;
    // dir=A5 ctrl=3C -> dir&ctrl=24
    mode = 1; mux_bus = 0; pt_en = 0; addr = 16'h7E31; #1
    check("R4 dir&ctrl", pad_oe, 8'h24);
    check("R5 live low", pad_out, 8'h31);
    addr = 16'h12C8; #1 check("R5 live follow", pad_out, 8'hC8);
    pt_en = 1; pt_oe = 8'h81; #1 check("R4 pt", pad_oe, 8'hA5);
  endtask

  task automatic t_mux;
    mode = 1; mux_bus = 1;
    @(negedge clk); ale = 1; addr = 16'hF04B; #1
    check("R6 transparent", pad_out, 8'h4B);
    @(negedge clk); ale = 0; addr = 16'h0F77; #1
    check("R6 held", pad_out, 8'h4B);
    @(negedge clk); addr = 16'h0002; #1
    check("R6 held later", pad_out, 8'h4B);
  endtask

  task automatic t_adr_in;
    mode = 2; pt_en = 1; pt_oe = 8'hFF; #1
    check("R7 no drive", pad_oe, 8'h00);
    @(negedge clk); ale = 1; pad_in = 8'hD3;
    @(negedge clk); ale = 0; pad_in = 8'h11;
    rd_sel = 3; #1 check("R7 captured", rd_data, 8'hD3);
    @(negedge clk); pad_in = 8'hEE; #1
    check("R7 hold", rd_data, 8'hD3);
    rd_sel = 0; #1 check("R9 input read", rd_data, 8'hEE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_regs();
    t_reg_oe();
    t_adr_out();
    t_mux();
    t_adr_in();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule